// File: doc/BRIEF.md
# Banked Shared Data Memory Crossbar

This block lets eight processing cores share one data memory that is split into sixteen single-cycle banks. Every core owns two request paths, a read path and a write path. Every bank likewise has one read port and one write port. A core may therefore read and write in the same cycle. The crossbar decodes the bank from each word address and forwards the winning request to that bank. It returns read data to the core that asked for it, one cycle after the grant.

A conflict arises only when two or more cores aim at the same bank through the same kind of port. Each bank keeps one round-robin arbiter for reads and another for writes. A core that loses is held with a per-core stall line, which the core uses as its clock-gate enable. While stalled, the core keeps its requests steady until every request it presented has been served. Contending requests are served on consecutive cycles with no gap between them. A port that was served while its core stays stalled on the other port is masked, so that it is not issued a second time.

The banks are synchronous RAMs outside this block. A bank's read data is valid the cycle after its read enable. When a read and a write reach the same word in the same cycle, the read returns the contents from before the write.

Top module: `shared_mem_xbar`

## Requirements
- R1: While reset is asserted and no request is present, stall_o, rd_valid_o, bank_rd_en_o and bank_wr_en_o are all zero. After reset, every arbiter pointer starts at core 0.
- R2: Word address bits [3:0] select the bank and bits [14:3+1] give the word offset inside the bank. Consecutive word addresses therefore fall in consecutive banks.
- R3: Requests that share no bank are all granted in the cycle they are presented, with stall_o low. A granted read raises rd_valid_o for that core in the next cycle, and the data appears on rd_data_o in that same cycle.
- R4: Only requests to the same bank through the same port kind conflict. A read and a write to one bank by different cores, or by the same core, are both granted in one cycle.
- R5: For each bank and each port kind, the winner is the first requesting core at or after the pointer, in ascending order with wrap-around. The pointer then moves to the winner plus one, modulo 8. A waiting core is therefore served within 7 stalled cycles.
- R6: A bank with pending requests on a port grants one of them every cycle. K contending cores complete on K consecutive cycles.
- R7: stall_o[c] is high in every cycle in which core c has a presented request that has not yet been granted. The first cycle in which stall_o[c] is low completes the operation.
- R8: Read data is steered to the requesting core from the bank that served its read.
- R9: A port granted while its core stays stalled is not granted again before the stall ends. Each read operation yields exactly one rd_valid_o pulse.
- R10: A read and a write to the same word, granted in the same cycle, return the old data. The crossbar does no write-to-read forwarding.
- R11: A granted write reaches the addressed bank and word, with its data unchanged, and a later read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 8 | Per-core read request |
| rd_addr_i | input | 8 x 15 | Per-core read word address |
| wr_req_i | input | 8 | Per-core write request |
| wr_addr_i | input | 8 x 15 | Per-core write word address |
| wr_data_i | input | 8 x 16 | Per-core write data |
| stall_o | output | 8 | Per-core stall, drives the clock-gate enable |
| rd_valid_o | output | 8 | Read data valid, one cycle after the grant |
| rd_data_o | output | 8 x 16 | Read data per core |
| bank_rd_en_o | output | 16 | Bank read enable |
| bank_rd_addr_o | output | 16 x 11 | Bank read word offset |
| bank_rd_data_i | input | 16 x 16 | Bank read data, valid the cycle after the enable |
| bank_wr_en_o | output | 16 | Bank write enable |
| bank_wr_addr_o | output | 16 x 11 | Bank write word offset |
| bank_wr_data_o | output | 16 x 16 | Bank write data |

## Verification
The assertions assume three things about the cores. Each core holds its requests, addresses and write data steady while its stall line is high. Each core drives no request during reset. The fairness property reads the previous cycle's grant, so it needs that reset quiet period. The stimulus follows this rule: every core moves to a new operation only after a cycle with its stall low, and all request lines stay at zero until reset is released. Random traffic keeps writes in a per-core slot of every bank and keeps reads in a region that nothing writes. This makes every expected read value known even when the grant order is not.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int N_CORE_DEF     = 8;
  localparam int N_BANK_DEF     = 16;
  localparam int BANK_WORDS_DEF = 2048;
  localparam int DATA_W_DEF     = 16;
endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] win_idx;
  logic          any;
  int            idx;

  // first requester at or after the pointer wins
  always_comb begin
    gnt_o   = '0;
    win_idx = '0;
    any     = 1'b0;
    idx     = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!any && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        win_idx    = IW'(idx);
        any        = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ptr_q <= '0;
    else if (any) ptr_q <= (win_idx == IW'(N - 1)) ? '0 : win_idx + IW'(1);
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && ((gnt_o & ~req_i) == '0)) else $error("grant not one-hot"); // R5
  AST_NO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o)) else $error("idle bank with pending request"); // R6
  AST_RR_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(req_i) > 1) |-> ((gnt_o & $past(gnt_o)) == '0)) else $error("winner repeated under contention"); // R5
endmodule

// File: rtl/xbar_port.sv
module xbar_port #(
  parameter int N_CORE = 8,
  parameter int N_BANK = 16,
  parameter int PW     = 11,
  localparam int BW    = $clog2(N_BANK)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_CORE-1:0]             req_i,
  input  logic [N_CORE-1:0][BW-1:0]     bank_i,
  input  logic [N_CORE-1:0][PW-1:0]     pl_i,
  output logic [N_CORE-1:0]             gnt_o,
  output logic [N_BANK-1:0]             en_o,
  output logic [N_BANK-1:0][PW-1:0]     pl_o
);
  logic [N_BANK-1:0][N_CORE-1:0] hit, win;

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic [PW-1:0] sel;
    for (genvar c = 0; c < N_CORE; c++) begin : g_hit
      assign hit[b][c] = req_i[c] && (bank_i[c] == BW'(b));
    end
    xbar_rr_arb #(.N(N_CORE)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (hit[b]),
      .gnt_o  (win[b])
    );
    always_comb begin
      sel = '0;
      for (int c = 0; c < N_CORE; c++)
        if (win[b][c]) sel = sel | pl_i[c];
    end
    assign pl_o[b] = sel;
    assign en_o[b] = |win[b];
  end

  always_comb begin
    gnt_o = '0;
    for (int b = 0; b < N_BANK; b++) gnt_o = gnt_o | win[b];
  end

  AST_ONE_CORE_PER_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gnt_o) == $countones(en_o)) else $error("bank served twice or core served twice"); // R4
endmodule

// File: rtl/shared_mem_xbar.sv
module shared_mem_xbar #(
  parameter int N_CORE     = xbar_pkg::N_CORE_DEF,
  parameter int N_BANK     = xbar_pkg::N_BANK_DEF,
  parameter int BANK_WORDS = xbar_pkg::BANK_WORDS_DEF,
  parameter int DATA_W     = xbar_pkg::DATA_W_DEF,
  localparam int BW = $clog2(N_BANK),
  localparam int OW = $clog2(BANK_WORDS),
  localparam int AW = BW + OW
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_CORE-1:0]             rd_req_i,
  input  logic [N_CORE-1:0][AW-1:0]     rd_addr_i,
  input  logic [N_CORE-1:0]             wr_req_i,
  input  logic [N_CORE-1:0][AW-1:0]     wr_addr_i,
  input  logic [N_CORE-1:0][DATA_W-1:0] wr_data_i,
  output logic [N_CORE-1:0]             stall_o,
  output logic [N_CORE-1:0]             rd_valid_o,
  output logic [N_CORE-1:0][DATA_W-1:0] rd_data_o,
  output logic [N_BANK-1:0]             bank_rd_en_o,
  output logic [N_BANK-1:0][OW-1:0]     bank_rd_addr_o,
  input  logic [N_BANK-1:0][DATA_W-1:0] bank_rd_data_i,
  output logic [N_BANK-1:0]             bank_wr_en_o,
  output logic [N_BANK-1:0][OW-1:0]     bank_wr_addr_o,
  output logic [N_BANK-1:0][DATA_W-1:0] bank_wr_data_o
);
  localparam int WPW = OW + DATA_W;

  logic [N_CORE-1:0][BW-1:0]  rd_bank, wr_bank, rd_bank_q;
  logic [N_CORE-1:0][OW-1:0]  rd_off;
  logic [N_CORE-1:0][WPW-1:0] wr_pl;
  logic [N_BANK-1:0][WPW-1:0] bank_wr_pl;
  logic [N_CORE-1:0] rd_pend, wr_pend, rd_gnt, wr_gnt;
  logic [N_CORE-1:0] rd_done_q, wr_done_q, rd_valid_q;

  // low address bits pick the bank so neighbouring words interleave
  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    assign rd_bank[c]   = rd_addr_i[c][BW-1:0];
    assign rd_off[c]    = rd_addr_i[c][AW-1:BW];
    assign wr_bank[c]   = wr_addr_i[c][BW-1:0];
    assign wr_pl[c]     = {wr_addr_i[c][AW-1:BW], wr_data_i[c]};
    assign rd_data_o[c] = bank_rd_data_i[rd_bank_q[c]];
  end

  // ports already served during the current stall are masked
  assign rd_pend = rd_req_i & ~rd_done_q;
  assign wr_pend = wr_req_i & ~wr_done_q;

  xbar_port #(.N_CORE(N_CORE), .N_BANK(N_BANK), .PW(OW)) u_rd_port (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (rd_pend),
    .bank_i (rd_bank),
    .pl_i   (rd_off),
    .gnt_o  (rd_gnt),
    .en_o   (bank_rd_en_o),
    .pl_o   (bank_rd_addr_o)
  );

  xbar_port #(.N_CORE(N_CORE), .N_BANK(N_BANK), .PW(WPW)) u_wr_port (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (wr_pend),
    .bank_i (wr_bank),
    .pl_i   (wr_pl),
    .gnt_o  (wr_gnt),
    .en_o   (bank_wr_en_o),
    .pl_o   (bank_wr_pl)
  );

  for (genvar b = 0; b < N_BANK; b++) begin : g_wbank
    assign bank_wr_addr_o[b] = bank_wr_pl[b][WPW-1:DATA_W];
    assign bank_wr_data_o[b] = bank_wr_pl[b][DATA_W-1:0];
  end

  assign stall_o    = (rd_pend & ~rd_gnt) | (wr_pend & ~wr_gnt);
  assign rd_valid_o = rd_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_done_q  <= '0;
      wr_done_q  <= '0;
      rd_valid_q <= '0;
      rd_bank_q  <= '0;
    end else begin
      rd_done_q  <= (rd_done_q | rd_gnt) & stall_o;
      wr_done_q  <= (wr_done_q | wr_gnt) & stall_o;
      rd_valid_q <= rd_gnt;
      for (int c = 0; c < N_CORE; c++)
        if (rd_gnt[c]) rd_bank_q[c] <= rd_bank[c];
    end
  end

  AST_NO_REGRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_done_q & rd_gnt) == '0) && ((wr_done_q & wr_gnt) == '0)) else $error("port granted twice in one stall"); // R9
  AST_VALID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o & ~$past(rd_req_i)) == '0) else $error("read data without a request"); // R3
  AST_STALL_ON_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o & ~(rd_req_i | wr_req_i)) == '0) else $error("stall without a request"); // R7
endmodule

// File: tb/tb_shared_mem_xbar.sv
`timescale 1ns/1ps
module tb_shared_mem_xbar;
  localparam int NC = 8, NB = 16, OW = 11, AW = 15, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NC-1:0] rd_req = '0, wr_req = '0;
  logic [NC-1:0][AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [NC-1:0][DW-1:0] wr_data = '0;
  logic [NC-1:0] stall, rd_valid;
  logic [NC-1:0][DW-1:0] rd_data;
  logic [NB-1:0] b_rd_en, b_wr_en;
  logic [NB-1:0][OW-1:0] b_rd_addr, b_wr_addr;
  logic [NB-1:0][DW-1:0] b_rd_data = '0, b_wr_data;

  shared_mem_xbar dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .wr_req_i(wr_req), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .stall_o(stall), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .bank_rd_en_o(b_rd_en), .bank_rd_addr_o(b_rd_addr), .bank_rd_data_i(b_rd_data),
    .bank_wr_en_o(b_wr_en), .bank_wr_addr_o(b_wr_addr), .bank_wr_data_o(b_wr_data)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  function automatic logic [DW-1:0] pat(int b, int o);
    return 16'hC000 ^ DW'(b * 256) ^ DW'(o * 17);
  endfunction
  function automatic logic [AW-1:0] wa(int b, int o);
    return AW'(o * NB + b); // R2: bank in bits [3:0]
  endfunction

  // bank storage model: read-first synchronous RAM, small offset window
  logic [DW-1:0] mem  [NB][16];
  logic [DW-1:0] gold [NB][16];
  initial for (int b = 0; b < NB; b++) for (int o = 0; o < 16; o++) begin
    mem[b][o] = pat(b, o); gold[b][o] = pat(b, o);
  end
  always @(posedge clk) for (int b = 0; b < NB; b++) begin
    if (b_rd_en[b]) b_rd_data[b] <= mem[b][b_rd_addr[b][3:0]];
    if (b_wr_en[b]) mem[b][b_wr_addr[b][3:0]] <= b_wr_data[b];
  end

  int got_cnt [NC];
  logic [DW-1:0] got_data [NC];
  always begin
    @(posedge clk); #2;
    for (int c = 0; c < NC; c++) if (rd_valid[c]) begin
      got_cnt[c]++; got_data[c] = rd_data[c];
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_op(input int c, input bit rd, input logic [AW-1:0] ra, input bit wr,
                       input logic [AW-1:0] wad, input logic [DW-1:0] wd,
                       output int stalls, output int nval, output logic [DW-1:0] rdat);
    int base;
    @(negedge clk);
    base = got_cnt[c];
    rd_req[c] = rd; rd_addr[c] = ra; wr_req[c] = wr; wr_addr[c] = wad; wr_data[c] = wd;
    stalls = 0;
    #1;
    while (stall[c]) begin @(negedge clk); #1; stalls++; end
    @(posedge clk); #3;
    rd_req[c] = 1'b0; wr_req[c] = 1'b0;
    nval = got_cnt[c] - base;
    rdat = got_data[c];
  endtask

  int st [NC];
  int nv [NC];
  logic [DW-1:0] dt [NC];

  // cores in mask read concurrently; same_bank: bank b offset 8+c, else bank c offset 9
  task automatic par_read(input logic [NC-1:0] m, input bit same_bank, input int b);
    for (int c = 0; c < NC; c++) if (m[c]) begin
      automatic int cc = c;
      automatic int bb = same_bank ? b : cc;
      automatic int oo = same_bank ? 8 + cc : 9;
      fork do_op(cc, 1'b1, wa(bb, oo), 1'b0, '0, '0, st[cc], nv[cc], dt[cc]); join_none
    end
    wait fork;
  endtask

  task automatic rand_core(input int c);
    for (int i = 0; i < 60; i++) begin
      automatic int kind = $urandom_range(0, 2);
      automatic int rb = $urandom_range(0, 15);
      automatic int ro = $urandom_range(8, 15);
      automatic int wb = $urandom_range(0, 15);
      automatic logic [DW-1:0] wd = DW'($urandom);
      int s, n; logic [DW-1:0] d;
      do_op(c, kind != 1, wa(rb, ro), kind != 0, wa(wb, c), wd, s, n, d);
      if (kind != 0) gold[wb][c] = wd;
      chk(s <= 7, "R5", "wait bound", s, 7);
      if (kind != 1) begin
        chk(n == 1, "R9", "valid pulses", n, 1);
        chk(d == pat(rb, ro), "R8", "steered data", d, pat(rb, ro));
      end
    end
  endtask

  task automatic readback_core(input int c);
    for (int b = 0; b < NB; b++) begin
      int s, n; logic [DW-1:0] d;
      do_op(c, 1'b1, wa(b, c), 1'b0, '0, '0, s, n, d);
      chk(d == gold[b][c], "R11", "readback", d, gold[b][c]);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    int s0, n0, s1, n1;
    logic [DW-1:0] d0, d1;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(stall == '0, "R1", "stall in reset", stall, 0);
    chk(rd_valid == '0, "R1", "valid in reset", rd_valid, 0);
    chk(b_rd_en == '0 && b_wr_en == '0, "R1", "bank enables in reset", {b_rd_en, b_wr_en}, 0);
    rst_n = 1'b1;

    // single read: no stall, one-cycle latency
    do_op(3, 1'b1, wa(5, 9), 1'b0, '0, '0, s0, n0, d0);
    chk(s0 == 0, "R3", "single read stall", s0, 0);
    chk(n0 == 1, "R3", "single read latency", n0, 1);
    chk(d0 == pat(5, 9), "R8", "single read data", d0, pat(5, 9));

    // consecutive words interleave across banks: no conflict
    par_read('1, 1'b0, 0);
    for (int c = 0; c < NC; c++) begin
      chk(st[c] == 0, "R2", "interleaved stall", st[c], 0);
      chk(dt[c] == pat(c, 9), "R8", "interleaved data", dt[c], pat(c, 9));
    end

    // words 16 apart share bank 5; bank 5 read pointer is at core 6
    fork
      do_op(0, 1'b1, wa(5, 10), 1'b0, '0, '0, s0, n0, d0);
      do_op(1, 1'b1, wa(5, 11), 1'b0, '0, '0, s1, n1, d1);
    join
    chk(s0 == 0 && s1 == 1, "R5", "bank 5 order", {s0, s1}, {32'd0, 32'd1});
    chk(d0 == pat(5, 10) && d1 == pat(5, 11), "R8", "bank 5 data", {d0, d1}, {pat(5, 10), pat(5, 11)});

    // all cores on bank 12, pointer at 0: one completion per cycle in order
    par_read('1, 1'b1, 12);
    for (int c = 0; c < NC; c++) begin
      chk(st[c] == c, "R6", "back-to-back order", st[c], c);
      chk(dt[c] == pat(12, 8 + c), "R8", "bank 12 data", dt[c], pat(12, 8 + c));
    end
    // pointer wrapped to 0; cores 1,4,6 served in that order
    par_read(8'b0101_0010, 1'b1, 12);
    chk(st[1] == 0 && st[4] == 1 && st[6] == 2, "R5", "subset order",
        {st[1], st[4], st[6]}, {32'd0, 32'd1, 32'd2});

    // same word read and written in one cycle returns old data
    fork
      do_op(0, 1'b1, wa(13, 2), 1'b0, '0, '0, s0, n0, d0);
      do_op(1, 1'b0, '0, 1'b1, wa(13, 2), 16'h5A5A, s1, n1, d1);
    join
    gold[13][2] = 16'h5A5A;
    chk(s0 == 0 && s1 == 0, "R4", "read+write same bank stall", {s0, s1}, 0);
    chk(d0 == pat(13, 2), "R10", "read during write", d0, pat(13, 2));
    do_op(0, 1'b1, wa(13, 2), 1'b0, '0, '0, s0, n0, d0);
    chk(d0 == 16'h5A5A, "R11", "write landed", d0, 16'h5A5A);

    // one core reads and writes the same bank in one cycle
    do_op(6, 1'b1, wa(14, 9), 1'b1, wa(14, 6), 16'h1234, s0, n0, d0);
    gold[14][6] = 16'h1234;
    chk(s0 == 0, "R4", "own read+write stall", s0, 0);
    chk(d0 == pat(14, 9), "R8", "own read data", d0, pat(14, 9));

    // core 4 read is free, write loses to core 2: one valid, one stall
    fork
      do_op(2, 1'b0, '0, 1'b1, wa(3, 2), 16'hBEEF, s1, n1, d1);
      do_op(4, 1'b1, wa(7, 10), 1'b1, wa(3, 4), 16'hF00D, s0, n0, d0);
    join
    gold[3][2] = 16'hBEEF; gold[3][4] = 16'hF00D;
    chk(s1 == 0 && s0 == 1, "R7", "partial stall", {s1, s0}, {32'd0, 32'd1});
    chk(n0 == 1, "R9", "single valid under stall", n0, 1);
    chk(d0 == pat(7, 10), "R8", "masked read data", d0, pat(7, 10));

    // random traffic
    for (int c = 0; c < NC; c++) begin
      automatic int cc = c;
      fork rand_core(cc); join_none
    end
    wait fork;

    // every core reads back its slot in every bank
    for (int c = 0; c < NC; c++) begin
      automatic int cc = c;
      fork readback_core(cc); join_none
    end
    wait fork;

    repeat (2) @(posedge clk);
    summary();
  end
endmodule